// File: doc/BRIEF.md
# Serial Memory Command Front-End

This block is the slave side of a four-wire serial bus in front of a small byte-wide memory. It oversamples the chip select, serial clock, serial input and pause lines with the system clock. From them it assembles 8-bit opcodes, 16-bit addresses and data bytes, most significant bit first. It then decodes six commands: set and clear of the program-enable latch, status read and status write, array read and array program. It streams array or status bytes back on the serial output and raises one-cycle requests for the neighbouring protection block. A register array model sits inside the block. Program bytes are written into it when the protection block grants the write.

A pause line lets the bus master freeze a transfer halfway through and continue it later from the same bit. A deselect at any point throws away a partial sequence. After reset, nothing is accepted until chip select has been seen falling. The status register lives outside this block and is streamed from `status_i`, so a status read works at any time, busy cycles included.

Top module: `spimem_front`

## Requirements
- R1: SI is captured on each rising SCK edge and SO changes only after a falling SCK edge. Opcode, address and data fields all travel most significant bit first.
- R2: While CS is high, `so_oe` is 0. Raising CS in the middle of a sequence discards it, and the next selection starts a fresh opcode.
- R3: After reset no command takes effect, and `so_oe` stays 0, until a high-to-low CS transition has been observed.
- R4: Opcode 0x06 raises `en_set_o` and opcode 0x04 raises `en_clr_o`, each for one cycle. The pulse comes when CS rises after exactly 8 bits. Any further bit before CS rises cancels the request.
- R5: Opcode 0x01 followed by one data byte raises `stat_wr_o` for one cycle when CS rises after exactly 16 bits, with the byte on `stat_data_o`. A shorter or longer sequence raises nothing.
- R6: Opcode 0x05 streams `status_i` continuously. The first byte is taken when the opcode completes, and each later byte is taken when the previous byte's last bit is shifted out. This works regardless of any busy state.
- R7: Opcode 0x03 plus a 16-bit address streams array bytes starting at that address. Only the low log2(DEPTH) address bits are used. The address increments after each byte and wraps from DEPTH-1 to 0.
- R8: Opcode 0x02 plus a 16-bit address writes each completed data byte at successive addresses, wrapping like R7, but only if `pgm_grant` is 1 when the byte completes. A partial byte is never written.
- R9: HOLD low, sampled while SCK is low, freezes the sequence. During the pause SCK and SI are ignored and `so_oe` is 0. HOLD high, sampled while SCK is low, resumes at the same bit.
- R10: Any opcode other than the six listed makes the block ignore SI until CS rises. No request is raised and SO stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out (valid when `so_oe` is 1) |
| so_oe | output | 1 | Output enable for SO; 0 means high impedance |
| status_i | input | 8 | Current status byte from the protection block |
| pgm_grant | input | 1 | 1 when array programming is permitted |
| en_set_o | output | 1 | One-cycle request to set the enable latch |
| en_clr_o | output | 1 | One-cycle request to clear the enable latch |
| stat_wr_o | output | 1 | One-cycle request to write the status byte |
| stat_data_o | output | 8 | Status byte accompanying `stat_wr_o` |

## Verification
A pin change is seen two system clocks later: one register samples the pins and one holds the sequence state. The new SO bit therefore appears two cycles after a falling SCK edge, and a request pulse appears two cycles after CS rises. The bench holds each SCK phase for four system clocks and reads SO at the moment it raises SCK, as a master would. Request pulses are counted continuously and compared after a settling wait that follows each deselect. Returned bytes go through an expected-value queue in transfer order.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_FW = 16;   // address field length on the wire

    localparam logic [BYTE_W-1:0] OPC_EN_SET  = 8'h06;
    localparam logic [BYTE_W-1:0] OPC_EN_CLR  = 8'h04;
    localparam logic [BYTE_W-1:0] OPC_ST_RD   = 8'h05;
    localparam logic [BYTE_W-1:0] OPC_ST_WR   = 8'h01;
    localparam logic [BYTE_W-1:0] OPC_ARR_RD  = 8'h03;
    localparam logic [BYTE_W-1:0] OPC_ARR_PGM = 8'h02;

    typedef enum logic [2:0] {
        ST_OPC,      // collecting opcode
        ST_ADDR,     // collecting address field
        ST_RD_ARR,   // streaming array bytes
        ST_RD_STAT,  // streaming status bytes
        ST_WR_STAT,  // collecting status byte
        ST_PGM,      // collecting program bytes
        ST_COMMIT,   // waiting for deselect to issue a request
        ST_SKIP      // ignoring the rest of the selection
    } cmd_st_t;

    typedef enum logic [1:0] {
        PD_NONE,
        PD_SET,
        PD_CLR,
        PD_STAT
    } pend_t;

    // Qualified pin events produced by the pin front-end
    typedef struct packed {
        logic armed;    // a CS fall has been seen since reset
        logic sel;      // armed and CS low
        logic cs_rise;  // armed and CS just went high
        logic hold;     // pause in effect
        logic rise;     // SCK rising edge accepted
        logic fall;     // SCK falling edge accepted
        logic si;       // sampled serial input
    } pin_ev_t;

    function automatic logic is_stream(cmd_st_t s);
        return (s == ST_RD_ARR) || (s == ST_RD_STAT);
    endfunction

endpackage

// File: rtl/spimem_pins.sv
module spimem_pins
    import spimem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    si,
    input  logic    hold_n,
    output pin_ev_t ev
);
    logic s_cs, p_cs, s_sck, p_sck, s_si, s_hold;
    logic armed_q, hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_cs   <= 1'b0;
            p_cs   <= 1'b0;
            s_sck  <= 1'b0;
            p_sck  <= 1'b0;
            s_si   <= 1'b0;
            s_hold <= 1'b1;
        end else begin
            s_cs   <= cs_n;
            p_cs   <= s_cs;
            s_sck  <= sck;
            p_sck  <= s_sck;
            s_si   <= si;
            s_hold <= hold_n;
        end
    end

    // Arming: needs a genuine high-to-low CS transition after reset
    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (p_cs && !s_cs)
            armed_q <= 1'b1;
    end

    // Pause changes only while SCK is low; dropped on deselect
    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= 1'b0;
        else if (s_cs)
            hold_q <= 1'b0;
        else if (!s_sck)
            hold_q <= !s_hold;
    end

    always_comb begin
        ev.armed   = armed_q;
        ev.sel     = armed_q && !s_cs;
        ev.cs_rise = armed_q && !p_cs && s_cs;
        ev.hold    = hold_q;
        ev.rise    = armed_q && !s_cs && !hold_q && s_sck && !p_sck;
        ev.fall    = armed_q && !s_cs && !hold_q && !s_sck && p_sck;
        ev.si      = s_si;
    end

endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [spimem_pkg::BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]             rd_addr,
    output logic [spimem_pkg::BYTE_W-1:0] rd_data
);
    logic [spimem_pkg::BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/spimem_cmd.sv
module spimem_cmd
    import spimem_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev,
    input  logic [BYTE_W-1:0] status_i,
    input  logic              pgm_grant,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              so_q,
    output cmd_st_t           st,
    output logic              en_set_o,
    output logic              en_clr_o,
    output logic              stat_wr_o,
    output logic [BYTE_W-1:0] stat_data_o
);
    localparam int CW = $clog2(ADDR_FW);

    logic [BYTE_W-2:0] sh;
    logic [CW-1:0]     cnt;
    logic [AW-1:0]     addr_sh;
    logic [AW-1:0]     ptr;
    logic [BYTE_W-1:0] out_sh;
    logic [2:0]        ocnt;
    logic              to_pgm;
    pend_t             pend;

    logic [BYTE_W-1:0] byte_in;
    logic [AW-1:0]     new_addr;

    assign byte_in  = {sh, ev.si};
    assign new_addr = {addr_sh[AW-2:0], ev.si};
    assign rd_addr  = (st == ST_ADDR) ? new_addr : ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_OPC;
            sh          <= '0;
            cnt         <= '0;
            addr_sh     <= '0;
            ptr         <= '0;
            out_sh      <= '0;
            ocnt        <= '0;
            to_pgm      <= 1'b0;
            pend        <= PD_NONE;
            so_q        <= 1'b0;
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            en_set_o    <= 1'b0;
            en_clr_o    <= 1'b0;
            stat_wr_o   <= 1'b0;
            stat_data_o <= '0;
        end else begin
            en_set_o  <= 1'b0;
            en_clr_o  <= 1'b0;
            stat_wr_o <= 1'b0;
            wr_en     <= 1'b0;
            if (!ev.sel) begin
                if (ev.cs_rise && st == ST_COMMIT) begin
                    unique case (pend)
                        PD_SET:  en_set_o  <= 1'b1;
                        PD_CLR:  en_clr_o  <= 1'b1;
                        PD_STAT: stat_wr_o <= 1'b1;
                        default: ;
                    endcase
                end
                st   <= ST_OPC;
                cnt  <= '0;
                ocnt <= '0;
                pend <= PD_NONE;
            end else begin
                if (ev.rise) begin
                    sh  <= byte_in[BYTE_W-2:0];
                    cnt <= cnt + 1'b1;
                    unique case (st)
                        ST_OPC: if (cnt == CW'(BYTE_W - 1)) begin
                            cnt <= '0;
                            unique case (byte_in)
                                OPC_EN_SET:  begin pend <= PD_SET; st <= ST_COMMIT; end
                                OPC_EN_CLR:  begin pend <= PD_CLR; st <= ST_COMMIT; end
                                OPC_ST_RD:   begin out_sh <= status_i; ocnt <= '0; st <= ST_RD_STAT; end
                                OPC_ST_WR:   st <= ST_WR_STAT;
                                OPC_ARR_RD:  begin to_pgm <= 1'b0; st <= ST_ADDR; end
                                OPC_ARR_PGM: begin to_pgm <= 1'b1; st <= ST_ADDR; end
                                default:     st <= ST_SKIP;
                            endcase
                        end
                        ST_ADDR: begin
                            addr_sh <= new_addr;
                            if (cnt == CW'(ADDR_FW - 1)) begin
                                cnt <= '0;
                                if (to_pgm) begin
                                    ptr <= new_addr;
                                    st  <= ST_PGM;
                                end else begin
                                    out_sh <= rd_data;
                                    ptr    <= new_addr + AW'(1);
                                    ocnt   <= '0;
                                    st     <= ST_RD_ARR;
                                end
                            end
                        end
                        ST_WR_STAT: if (cnt == CW'(BYTE_W - 1)) begin
                            cnt         <= '0;
                            stat_data_o <= byte_in;
                            pend        <= PD_STAT;
                            st          <= ST_COMMIT;
                        end
                        ST_PGM: if (cnt == CW'(BYTE_W - 1)) begin
                            cnt     <= '0;
                            wr_en   <= pgm_grant;
                            wr_addr <= ptr;
                            wr_data <= byte_in;
                            ptr     <= ptr + AW'(1);
                        end
                        ST_COMMIT: begin
                            pend <= PD_NONE;
                            st   <= ST_SKIP;
                        end
                        default: ;
                    endcase
                end
                if (ev.fall && is_stream(st)) begin
                    so_q   <= out_sh[BYTE_W-1];
                    out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
                    ocnt   <= ocnt + 1'b1;
                    if (ocnt == 3'd7) begin
                        ocnt <= '0;
                        if (st == ST_RD_STAT) begin
                            out_sh <= status_i;
                        end else begin
                            out_sh <= rd_data;
                            ptr    <= ptr + AW'(1);
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spimem_front.sv
module spimem_front
    import spimem_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    input  logic [BYTE_W-1:0] status_i,
    input  logic              pgm_grant,
    output logic              en_set_o,
    output logic              en_clr_o,
    output logic              stat_wr_o,
    output logic [BYTE_W-1:0] stat_data_o
);
    localparam int AW = $clog2(DEPTH);

    pin_ev_t           ev;
    cmd_st_t           st;
    logic              so_q;
    logic              wr_en;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    spimem_pins u_pins (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .sck    (sck),
        .si     (si),
        .hold_n (hold_n),
        .ev     (ev)
    );

    spimem_cmd #(.AW(AW)) u_cmd (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .status_i    (status_i),
        .pgm_grant   (pgm_grant),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .so_q        (so_q),
        .st          (st),
        .en_set_o    (en_set_o),
        .en_clr_o    (en_clr_o),
        .stat_wr_o   (stat_wr_o),
        .stat_data_o (stat_data_o)
    );

    spimem_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign so    = so_q;
    assign so_oe = ev.sel && !ev.hold && is_stream(st);

endmodule

// File: rtl/spimem_front_chk.sv
module spimem_front_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic so_oe,
    input logic en_set_o,
    input logic en_clr_o,
    input logic stat_wr_o,
    input logic armed,
    input logic hold_act
);
    // R2: settled deselect keeps the output disabled
    a_r2_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !so_oe);

    // R3: nothing happens before the arming CS fall
    a_r3_unarmed_idle: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !(en_set_o || en_clr_o || stat_wr_o || so_oe));

    // R4, R5: at most one request per cycle
    a_r4_one_request: assert property (@(posedge clk) disable iff (rst)
        $onehot0({en_set_o, en_clr_o, stat_wr_o}));

    // R4: set request lasts one cycle
    a_r4_set_single: assert property (@(posedge clk) disable iff (rst)
        en_set_o |=> !en_set_o);

    // R5: status write request lasts one cycle
    a_r5_stat_single: assert property (@(posedge clk) disable iff (rst)
        stat_wr_o |=> !stat_wr_o);

    // R9: output disabled during a pause
    a_r9_pause_hiz: assert property (@(posedge clk) disable iff (rst)
        hold_act |-> !so_oe);
endmodule

bind spimem_front spimem_front_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .so_oe     (so_oe),
    .en_set_o  (en_set_o),
    .en_clr_o  (en_clr_o),
    .stat_wr_o (stat_wr_o),
    .armed     (ev.armed),
    .hold_act  (ev.hold)
);

// File: tb/spimem_front_tb_top.sv
`timescale 1ns/1ps
module spimem_front_tb_top;
    localparam int H = 4;   // system clocks per SCK phase

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;
    logic [7:0] status_i = 8'h00;
    logic pgm_grant = 1'b0;
    logic en_set_o, en_clr_o, stat_wr_o;
    logic [7:0] stat_data_o;

    int checks = 0, errors = 0, cycles = 0;
    int set_cnt = 0, clr_cnt = 0, stw_cnt = 0;
    logic [7:0] last_stat = 8'h00;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    spimem_front dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .status_i(status_i), .pgm_grant(pgm_grant),
        .en_set_o(en_set_o), .en_clr_o(en_clr_o), .stat_wr_o(stat_wr_o),
        .stat_data_o(stat_data_o)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Request monitors
    always @(posedge clk) begin
        cycles++;
        if (!rst) begin
            if (en_set_o) set_cnt++;
            if (en_clr_o) clr_cnt++;
            if (stat_wr_o) begin stw_cnt++; last_stat = stat_data_o; end
        end
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    // Scoreboard monitor: compares returned bytes in order
    always @(negedge clk) begin
        if (exp_q.size() > 0 && got_q.size() > 0) begin
            logic [7:0] e, g;
            string t;
            e = exp_q.pop_front();
            g = got_q.pop_front();
            t = tag_q.pop_front();
            chk(g == e, t, g, e);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pause();
        hold_n = 1'b0;
        idle(H);
        chk(so_oe == 1'b0, "R9 pause hiz", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
            si = ~si; sck = 1'b1; idle(H); sck = 1'b0; idle(H);
        end
        hold_n = 1'b1;
        idle(H);
    endtask

    // Shift n bits of tx (MSB of the n first); optional pause after bit hold_at
    task automatic xbits(input logic [7:0] tx, input int n, input int hold_at,
                         output logic [7:0] rx);
        rx = '0;
        for (int i = n - 1; i >= 0; i--) begin
            si = tx[i];
            idle(H);
            sck = 1'b1;
            rx[i] = so;
            idle(H);
            sck = 1'b0;
            if (i == hold_at) pause();
        end
        idle(H);
    endtask

    task automatic xbyte(input logic [7:0] tx);
        logic [7:0] r;
        xbits(tx, 8, -1, r);
    endtask

    task automatic expect_byte(input logic [7:0] e, input string t, input int hold_at);
        logic [7:0] r;
        exp_q.push_back(e);
        tag_q.push_back(t);
        xbits(8'h00, 8, hold_at, r);
        got_q.push_back(r);
    endtask

    task automatic sel();   cs_n = 1'b0; idle(H); endtask
    task automatic desel(); cs_n = 1'b1; idle(2 * H); endtask

    task automatic cmd_addr(input logic [7:0] op, input logic [15:0] a);
        sel();
        xbyte(op);
        xbyte(a[15:8]);
        xbyte(a[7:0]);
    endtask

    initial begin
        logic [7:0] r;
        int s0;
        // Reset with CS already low: no arming fall yet
        idle(5);
        rst = 1'b0;
        idle(2);
        chk(so_oe == 1'b0, "R2 reset so_oe", so_oe, 0);

        // R3: commands before the arming fall do nothing
        xbyte(8'h06);
        cs_n = 1'b1; idle(2 * H);
        chk(set_cnt == 0, "R3 no set before arm", set_cnt, 0);

        // R4: set and clear
        sel(); xbyte(8'h06); desel();
        chk(set_cnt == 1, "R4 set pulse", set_cnt, 1);
        sel(); xbyte(8'h04); desel();
        chk(clr_cnt == 1, "R4 clear pulse", clr_cnt, 1);
        sel(); xbyte(8'h06); xbits(8'h01, 1, -1, r); desel();
        chk(set_cnt == 1, "R4 extra bit cancels", set_cnt, 1);

        // R2: partial opcode discarded, next selection starts fresh
        sel(); xbits(8'h00, 4, -1, r); desel();
        sel(); xbyte(8'h06); desel();
        chk(set_cnt == 2, "R2 restart after partial", set_cnt, 2);

        // R5: status write
        sel(); xbyte(8'h01); xbyte(8'h8C); desel();
        chk(stw_cnt == 1, "R5 status write pulse", stw_cnt, 1);
        chk(last_stat == 8'h8C, "R5 status data", last_stat, 8'h8C);
        sel(); xbyte(8'h01); xbits(8'h0F, 4, -1, r); desel();
        chk(stw_cnt == 1, "R5 short write ignored", stw_cnt, 1);

        // R6/R1: status stream, reloaded at each byte boundary
        status_i = 8'hA5;
        sel(); xbyte(8'h05);
        status_i = 8'h3C;
        expect_byte(8'hA5, "R6 R1 status byte0", -1);
        expect_byte(8'h3C, "R6 status byte1", -1);
        desel();
        chk(so_oe == 1'b0, "R2 hiz after deselect", so_oe, 0);

        // R8: program with grant across the wrap point
        pgm_grant = 1'b1;
        cmd_addr(8'h02, 16'h00FE);
        xbyte(8'h11); xbyte(8'h22); xbyte(8'h33);
        xbits(8'h0A, 4, -1, r);   // partial byte, never written
        desel();
        pgm_grant = 1'b0;
        cmd_addr(8'h02, 16'h0010);
        xbyte(8'h77);
        desel();

        // R7: read with increment and wrap
        cmd_addr(8'h03, 16'h00FE);
        expect_byte(8'h11, "R7 R8 read FE", -1);
        expect_byte(8'h22, "R7 R8 read FF", -1);
        expect_byte(8'h33, "R7 R8 wrap to 00", -1);
        expect_byte(8'h00, "R8 partial not written", -1);
        desel();
        // R7: upper address bits ignored
        cmd_addr(8'h03, 16'h01FF);
        expect_byte(8'h22, "R7 alias high bits", -1);
        desel();
        // R8: no grant means no write
        cmd_addr(8'h03, 16'h0010);
        expect_byte(8'h00, "R8 no grant", -1);
        desel();

        // R9: pause inside the address and inside a data byte
        sel();
        xbyte(8'h03);
        xbits(8'h00, 8, 3, r);
        xbyte(8'hFE);
        expect_byte(8'h11, "R9 resume in data", 5);
        expect_byte(8'h22, "R9 after pause", -1);
        desel();

        // R10: unknown opcode
        s0 = set_cnt;
        sel(); xbyte(8'hAB); xbyte(8'h06); desel();
        chk(set_cnt == s0, "R10 unknown then set", set_cnt, s0);
        sel(); xbyte(8'hAB); xbyte(8'h05); xbits(8'h00, 4, -1, r);
        chk(so_oe == 1'b0, "R10 no output", so_oe, 0);
        desel();

        idle(10);
        chk(exp_q.size() == 0 && got_q.size() == 0, "R1 scoreboard drained",
            exp_q.size(), 0);
        summary();
    end

endmodule